// File: doc/BRIEF.md
# Attestation-Gated Platform Power Sequencer

This block brings a server platform out of power-on in stages, and each stage opens only on a verification verdict. At power-up nothing downstream is enabled. The management controller gets power only after firmware reports that its image is authentic. Once that happens, the expansion slots that the platform expects to be populated are powered. A challenge window then opens in which each populated slot's component must answer. In parallel the block waits for the verdict on the host boot image.

The host is released from reset only when two things are true: the host image has passed, and the slot challenges have been resolved. A failed management-controller or host image verdict drops the platform to a standby state with every downstream enable low. A slot that stays silent is handled according to a 2-bit failure policy. Hashing, signature checks and the challenge messages are done elsewhere. Firmware delivers their outcomes as single-cycle pulses and level bits.

Top module: `boot_gate_seq`

## Requirements
- R1: While reset is asserted and directly after it, mc_pwr_en is 0, slot_pwr_en is all zero, host_rst_hold is 1, standby is 0 and fail_report is 0.
- R2: mc_pwr_en rises at the clock edge that samples mc_done=1 with mc_pass=1, and never before; a host_done pulse arriving before that edge is ignored.
- R3: At the edge that enables the management controller, slot_pwr_en takes the value of slot_expect (bit i = slot i). After that edge a slot enable can only fall; it never rises.
- R4: host_rst_hold stays 1 until the host image has passed (host_done=1 with host_pass=1) and the challenge window has resolved. It falls at the edge where the later of the two happens.
- R5: The challenge window ends as soon as every expected slot has shown slot_resp=1, without waiting for the timeout.
- R6: The window counts clock edges from the management-controller enable edge. A response is still accepted at the edge numbered tmo_cycles+1, and any expected slot still silent after that edge counts as failed.
- R7: With fail_policy 0 or 3, failed slots lose their enable at the window-end edge, fail_report pulses, and boot continues.
- R8: With fail_policy 1, failed slots stay powered, fail_report pulses, and boot continues.
- R9: With fail_policy 2, the first window that ends with a failure opens a second window of the same length, with no report and no change to the enables. Slots that answered in either window count as answered. Slots still silent at the end of the second window are unpowered, and fail_report pulses.
- R10: mc_done=1 with mc_pass=0 enters standby: standby=1, every enable 0, host_rst_hold=1, and fail_report pulses.
- R11: host_done=1 with host_pass=0, after the management controller is enabled and before the host is released, enters standby in the same way as R10.
- R12: fail_report is high for exactly one cycle per event. Standby persists until reset, and any further pulse on mc_done, mc_pass, host_done or host_pass is ignored there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_done | input | 1 | Management-controller image verdict strobe |
| mc_pass | input | 1 | Verdict value for mc_done (1 = authentic) |
| host_done | input | 1 | Host boot image verdict strobe |
| host_pass | input | 1 | Verdict value for host_done (1 = authentic) |
| slot_expect | input | NSLOT | Slots expected to hold a component, sampled at the management-controller enable |
| slot_resp | input | NSLOT | Per-slot challenge answered flag |
| tmo_cycles | input | TW | Challenge window length in cycles |
| fail_policy | input | 2 | 0 platform default, 1 report only, 2 retry once, 3 unpower |
| mc_pwr_en | output | 1 | Management-controller power enable |
| slot_pwr_en | output | NSLOT | Per-slot power enable |
| host_rst_hold | output | 1 | Host held in reset while 1 |
| standby | output | 1 | Platform parked on standby power |
| fail_report | output | 1 | One-cycle failure report strobe |

## Verification
The bench puts responses at the exact closing edge of a window, where an off-by-one counter would either accept a late answer or drop one that arrives in time. It times the host image verdict both before and after the window closes. A design that released the host on the image verdict alone would let the host run while a slot's answer is still outstanding. The retry policy is run with one slot answering only in the second window: reporting too early, or forgetting answers across windows, shows up as a wrong enable vector. Image failures and stray pulses after standby check that the block neither re-enables power nor repeats the report.

// File: rtl/boot_gate_seq.sv
module boot_gate_seq #(
  parameter int NSLOT = 4,
  parameter int TW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mc_done,
  input  logic             mc_pass,
  input  logic             host_done,
  input  logic             host_pass,
  input  logic [NSLOT-1:0] slot_expect,
  input  logic [NSLOT-1:0] slot_resp,
  input  logic [TW-1:0]    tmo_cycles,
  input  logic [1:0]       fail_policy,
  output logic             mc_pwr_en,
  output logic [NSLOT-1:0] slot_pwr_en,
  output logic             host_rst_hold,
  output logic             standby,
  output logic             fail_report
);

  typedef enum logic [2:0] {ST_MC, ST_CHAL, ST_HOSTW, ST_RUN, ST_STBY} st_t;
  localparam logic [1:0] POL_REPORT = 2'd1;
  localparam logic [1:0] POL_RETRY  = 2'd2;

  st_t              st;
  logic [NSLOT-1:0] exp_q, seen_q;
  logic [TW-1:0]    cnt;
  logic             host_ok, retried;

  logic [NSLOT-1:0] seen_n, missing;
  logic             host_good, chal_end, do_retry, chal_final, go_stby, go_run;

  assign seen_n     = seen_q | (slot_resp & exp_q);
  assign missing    = exp_q & ~seen_n;
  assign host_good  = host_ok | (host_done & host_pass);
  assign chal_end   = (missing == '0) || (cnt >= tmo_cycles);
  assign do_retry   = chal_end && (missing != '0) && (fail_policy == POL_RETRY) && !retried;
  assign chal_final = chal_end && !do_retry;

  assign go_stby = (st == ST_MC && mc_done && !mc_pass)
                || ((st == ST_CHAL || st == ST_HOSTW) && host_done && !host_pass);
  assign go_run  = (st == ST_CHAL && chal_final && host_good)
                || (st == ST_HOSTW && host_done && host_pass);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= ST_MC;
      mc_pwr_en     <= 1'b0;
      slot_pwr_en   <= '0;
      host_rst_hold <= 1'b1;
      standby       <= 1'b0;
      fail_report   <= 1'b0;
      exp_q         <= '0;
      seen_q        <= '0;
      cnt           <= '0;
      host_ok       <= 1'b0;
      retried       <= 1'b0;
    end else begin
      fail_report <= 1'b0;
      if (go_stby) begin
        st            <= ST_STBY;
        standby       <= 1'b1;
        mc_pwr_en     <= 1'b0;
        slot_pwr_en   <= '0;
        host_rst_hold <= 1'b1;
        fail_report   <= 1'b1;
      end else begin
        if (go_run) begin
          st            <= ST_RUN;
          host_rst_hold <= 1'b0;
        end
        case (st)
          ST_MC: if (mc_done && mc_pass) begin
            st          <= ST_CHAL;
            mc_pwr_en   <= 1'b1;
            slot_pwr_en <= slot_expect;
            exp_q       <= slot_expect;
            seen_q      <= '0;
            cnt         <= '0;
          end
          ST_CHAL: begin
            host_ok <= host_good;
            seen_q  <= seen_n;
            cnt     <= cnt + 1'b1;
            if (do_retry) begin
              retried <= 1'b1;
              cnt     <= '0;
            end else if (chal_final) begin
              if (!host_good) st <= ST_HOSTW;
              if (missing != '0) begin
                fail_report <= 1'b1;
                if (fail_policy != POL_REPORT) slot_pwr_en <= slot_pwr_en & ~missing;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/boot_gate_seq_chk.sv
module boot_gate_seq_chk #(
  parameter int NSLOT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mc_done,
  input logic             mc_pass,
  input logic             mc_pwr_en,
  input logic [NSLOT-1:0] slot_pwr_en,
  input logic             host_rst_hold,
  input logic             standby,
  input logic             fail_report
);

  assert_mc_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mc_pwr_en) |-> $past(mc_done && mc_pass));

  assert_pre_mc_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mc_pwr_en |-> (host_rst_hold && slot_pwr_en == '0));

  assert_slot_no_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_pwr_en && $past(mc_pwr_en)) |-> ((slot_pwr_en & ~$past(slot_pwr_en)) == '0));

  assert_release_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_rst_hold) |-> (mc_pwr_en && !standby));

  assert_stby_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (!mc_pwr_en && slot_pwr_en == '0 && host_rst_hold));

  assert_report_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fail_report |=> !fail_report);

  assert_stby_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> standby);

endmodule

bind boot_gate_seq boot_gate_seq_chk #(.NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .mc_done(mc_done), .mc_pass(mc_pass),
  .mc_pwr_en(mc_pwr_en), .slot_pwr_en(slot_pwr_en), .host_rst_hold(host_rst_hold),
  .standby(standby), .fail_report(fail_report)
);

// File: tb/sim_boot_gate_seq.sv
module sim_boot_gate_seq;
  localparam int NSLOT = 4;
  localparam int TW    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mc_done = 0, mc_pass = 0, host_done = 0, host_pass = 0;
  logic [NSLOT-1:0] slot_expect = '0, slot_resp = '0;
  logic [TW-1:0] tmo_cycles = '0;
  logic [1:0] fail_policy = '0;
  logic mc_pwr_en, host_rst_hold, standby, fail_report;
  logic [NSLOT-1:0] slot_pwr_en;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  boot_gate_seq #(.NSLOT(NSLOT), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .mc_done(mc_done), .mc_pass(mc_pass),
    .host_done(host_done), .host_pass(host_pass), .slot_expect(slot_expect),
    .slot_resp(slot_resp), .tmo_cycles(tmo_cycles), .fail_policy(fail_policy),
    .mc_pwr_en(mc_pwr_en), .slot_pwr_en(slot_pwr_en), .host_rst_hold(host_rst_hold),
    .standby(standby), .fail_report(fail_report)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start(input int pol, input int expv, input int tmo);
    rst_n = 1'b0;
    mc_done = 0; mc_pass = 0; host_done = 0; host_pass = 0; slot_resp = '0;
    fail_policy = pol[1:0];
    slot_expect = expv[NSLOT-1:0];
    tmo_cycles  = tmo[TW-1:0];
    step();
    step();
    rst_n = 1'b1;
  endtask

  task automatic mc_ok();
    mc_done = 1; mc_pass = 1;
    step();
    mc_done = 0; mc_pass = 0;
  endtask

  task automatic host_ok();
    host_done = 1; host_pass = 1;
    step();
    host_done = 0; host_pass = 0;
  endtask

  task automatic t_reset();
    start(3, 4'b1111, 8);
    chk("R1 mc_pwr_en", mc_pwr_en, 0);
    chk("R1 slot_pwr_en", slot_pwr_en, 0);
    chk("R1 host_rst_hold", host_rst_hold, 1);
    chk("R1 standby", standby, 0);
    chk("R1 fail_report", fail_report, 0);
  endtask

  task automatic t_normal();
    start(3, 4'b1011, 10);
    host_ok();
    step();
    chk("R2 early host ignored mc", mc_pwr_en, 0);
    chk("R2 early host ignored hold", host_rst_hold, 1);
    mc_ok();
    chk("R2 mc enabled", mc_pwr_en, 1);
    chk("R3 slots follow expect", slot_pwr_en, 4'b1011);
    slot_resp = 4'b1011;
    step();
    slot_resp = '0;
    chk("R4 hold until host", host_rst_hold, 1);
    host_ok();
    chk("R5 released before timeout", host_rst_hold, 0);
    chk("R5 slots kept", slot_pwr_en, 4'b1011);
    chk("R5 no report", fail_report, 0);
  endtask

  task automatic t_pol3();
    start(3, 4'b1111, 5);
    mc_ok();
    slot_resp = 4'b0011; host_done = 1; host_pass = 1;
    step();
    slot_resp = '0; host_done = 0; host_pass = 0;
    repeat (4) step();
    chk("R6 still waiting hold", host_rst_hold, 1);
    chk("R6 still waiting slots", slot_pwr_en, 4'b1111);
    step();
    chk("R7 silent slots off", slot_pwr_en, 4'b0011);
    chk("R4 released at window end", host_rst_hold, 0);
    chk("R7 report", fail_report, 1);
    step();
    chk("R12 report one cycle", fail_report, 0);
  endtask

  task automatic t_pol0_edge();
    start(0, 4'b0111, 5);
    mc_ok();
    slot_resp = 4'b0001;
    step();
    slot_resp = '0;
    repeat (4) step();
    slot_resp = 4'b0010;
    step();
    slot_resp = '0;
    chk("R6 last-edge answer kept, R7 policy0", slot_pwr_en, 4'b0011);
    chk("R7 policy0 report", fail_report, 1);
    chk("R4 hold without host verdict", host_rst_hold, 1);
    host_ok();
    chk("R4 release after host", host_rst_hold, 0);
  endtask

  task automatic t_pol1();
    start(1, 4'b0011, 3);
    mc_ok();
    repeat (3) step();
    chk("R8 no report before end", fail_report, 0);
    step();
    chk("R8 report", fail_report, 1);
    chk("R8 slots stay powered", slot_pwr_en, 4'b0011);
    host_ok();
    chk("R8 boot continues", host_rst_hold, 0);
  endtask

  task automatic t_pol2();
    start(2, 4'b0111, 3);
    mc_ok();
    slot_resp = 4'b0001;
    step();
    slot_resp = '0;
    repeat (3) step();
    chk("R9 no report at first end", fail_report, 0);
    chk("R9 slots unchanged at first end", slot_pwr_en, 4'b0111);
    step();
    slot_resp = 4'b0010;
    step();
    slot_resp = '0;
    step();
    chk("R9 still retrying", slot_pwr_en, 4'b0111);
    step();
    chk("R9 only silent slot off", slot_pwr_en, 4'b0011);
    chk("R9 report after retry", fail_report, 1);
    host_ok();
    chk("R9 boot continues", host_rst_hold, 0);
  endtask

  task automatic t_mc_fail();
    start(3, 4'b1111, 5);
    mc_done = 1; mc_pass = 0;
    step();
    mc_done = 0;
    chk("R10 standby", standby, 1);
    chk("R10 report", fail_report, 1);
    chk("R10 mc off", mc_pwr_en, 0);
    chk("R10 hold", host_rst_hold, 1);
    step();
    chk("R12 report one cycle", fail_report, 0);
    mc_ok();
    chk("R12 mc pass ignored in standby", mc_pwr_en, 0);
    chk("R12 standby stays", standby, 1);
    chk("R12 no second report", fail_report, 0);
  endtask

  task automatic t_host_fail();
    start(3, 4'b0011, 20);
    mc_ok();
    host_done = 1; host_pass = 0;
    step();
    host_done = 0;
    chk("R11 standby", standby, 1);
    chk("R11 mc off", mc_pwr_en, 0);
    chk("R11 slots off", slot_pwr_en, 0);
    chk("R11 hold", host_rst_hold, 1);
    chk("R11 report", fail_report, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_normal();
    t_pol3();
    t_pol0_edge();
    t_pol1();
    t_pol2();
    t_mc_fail();
    t_host_fail();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule